// File: doc/BRIEF.md
# Nested Interrupt Entry and Exit Sequencer

This block decides which of a small set of interrupt sources gets the processor, and when. Each source has a pending flag, an enable flag, an active flag and an 8-bit programmable urgency, where a smaller number is more urgent. The block also holds a running base priority for the code that is currently executing. It sequences entry into a handler (saving a register frame), the handler's run, and the return (restoring the frame). It models the frame save and restore as fixed cycle counts. It does not perform memory traffic, and it does not look up vector table contents.

Three timing-dependent behaviours are built in:
- **Nesting.** A more urgent request that arrives during a handler saves a second frame and runs at once.
- **Tail-chaining.** A request that waits until a return is entered directly, with no restore and re-save in between.
- **Late arrival.** A more urgent request that arrives while a frame is still being saved takes over the entry that is in progress.

All pins are plain control and status lines. No stream moves through the block, so there is no valid/ready pair and no back-pressure. `vec_start` is a one-cycle pulse that the core must accept in the cycle it appears.

Top module: `irq_nest_seq`

## Requirements
- R1: A source is eligible when it is both pending and enabled. Among eligible sources the one with the numerically smallest priority is chosen. A configuration write (`cfg_we` with `cfg_idx`, `cfg_prio`, `cfg_en`) takes effect from the next cycle.
- R2: After reset the following all hold:
  - nothing is pending or active;
  - `busy` and `vec_start` are 0;
  - `base_prio` is the idle value 256.
  Whenever no handler is active, `base_prio` is 256.
- R3: An eligible request starts an entry only when its priority is strictly smaller than `base_prio`. A request of equal or larger value stays pending and causes no `busy` and no `vec_start`.
- R4: On handler entry:
  - `vec_start` pulses for one cycle, with `vec_idx` naming the source;
  - that source's pending bit clears and its active bit sets;
  - `base_prio` takes that source's priority.
- R5: A preempting request during a handler saves another frame (8 `busy` cycles) and then enters. The return of the nested handler restores that frame (8 `busy` cycles), gives no `vec_start`, and puts `base_prio` back to the interrupted handler's priority. The interrupted handler's active bit stays set.
- R6: On a return (`hdl_ret` pulse), an eligible pending source may be more urgent than the priority being returned to. In that case the block enters it without any `busy` cycle. `vec_start` appears at most 6 cycles after the cycle in which `hdl_ret` was sampled.
- R7: If a more urgent request arrives while a frame is being saved, the source entered when the save completes is the most urgent eligible one. The source that began the entry remains pending.
- R8: A frame save or restore keeps `busy` high for exactly 8 consecutive cycles, one per saved word. `vec_start` follows in the cycle after a save ends.
- R9: Among eligible sources of equal priority, the lowest index is chosen.
- R10: A disabled source can become pending and stays pending, but it is never entered. It is entered once it is enabled.
- R11: When the last active handler returns and nothing eligible beats the idle level, the block restores the frame in 8 `busy` cycles. It then shows `base_prio` 256 with no source active and no `vec_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 5 | One-cycle request pulses, one bit per source; each sets that source's pending bit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Source written by `cfg_we` |
| cfg_prio | input | 8 | Priority written (smaller is more urgent) |
| cfg_en | input | 1 | Enable written |
| hdl_ret | input | 1 | One-cycle return strobe from the running handler |
| busy | output | 1 | High while a frame is being saved or restored |
| vec_start | output | 1 | One-cycle pulse: a handler starts now |
| vec_idx | output | 3 | Source index for the handler being started |
| base_prio | output | 9 | Current base priority; 256 when idle |
| pend_o | output | 5 | Pending flags |
| act_o | output | 5 | Active flags |

## Verification
The bench sweeps every ordered pair of sources under two priority layouts and checks the following:
- A more urgent second request must nest. A design that compared with less-or-equal would nest on equal priorities.
- A less urgent second request must tail-chain with no `busy` cycles. A design that always restored the frame would show 8 `busy` cycles and a slow vector.
- A request injected while a frame is still being saved must win the entry. A design that latched the source at the start of the save would vector to the wrong index.
- With all sources raised together, the handlers must come out in priority order. This run includes equal values, which a design without index tie-breaking would reorder.
- A disabled source must stay pending without ever being entered.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  // Sequencer phases
  typedef enum logic [2:0] {
    SQ_THREAD  = 3'd0,  // no handler active
    SQ_STACK   = 3'd1,  // saving a frame
    SQ_RUN     = 3'd2,  // handler executing
    SQ_UNSTACK = 3'd3,  // restoring a frame
    SQ_CHAIN   = 3'd4   // switching handlers without restoring
  } sq_state_e;

endpackage

// File: rtl/irq_src_bank.sv
// Per-source state: pending, enable, priority, active.
module irq_src_bank #(
  parameter int N_SRC  = 5,
  parameter int PRIO_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SRC-1:0]        req,
  input  logic                    cfg_we,
  input  logic [IDX_W-1:0]        cfg_idx,
  input  logic [PRIO_W-1:0]       cfg_prio,
  input  logic                    cfg_en,
  input  logic                    take_vld,
  input  logic [IDX_W-1:0]        take_idx,
  input  logic                    drop_vld,
  input  logic [IDX_W-1:0]        drop_idx,
  output logic [N_SRC-1:0]        pend,
  output logic [N_SRC-1:0]        en,
  output logic [N_SRC-1:0]        act,
  output logic [N_SRC*PRIO_W-1:0] prio_flat
);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic              pend_q;
    logic              en_q;
    logic              act_q;
    logic [PRIO_W-1:0] prio_q;
    logic              hit_take;
    logic              hit_drop;
    logic              hit_cfg;

    assign hit_take = take_vld && (take_idx == IDX_W'(i));
    assign hit_drop = drop_vld && (drop_idx == IDX_W'(i));
    assign hit_cfg  = cfg_we && (cfg_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        en_q   <= 1'b0;
        act_q  <= 1'b0;
        prio_q <= '1;
      end else begin
        pend_q <= (pend_q & ~hit_take) | req[i];
        if (hit_cfg) begin
          en_q   <= cfg_en;
          prio_q <= cfg_prio;
        end
        if (hit_take)      act_q <= 1'b1;
        else if (hit_drop) act_q <= 1'b0;
      end
    end

    assign pend[i] = pend_q;
    assign en[i]   = en_q;
    assign act[i]  = act_q;
    assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q;

    // A disabled pending source is never taken, so it stays pending
    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !en_q) |=> pend_q) else $error("disabled source lost pending"); // R10

    // Entry is never granted to a disabled source
    AST_TAKE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      hit_take |-> (en_q && pend_q)) else $error("entry of ineligible source"); // R1
  end

endmodule

// File: rtl/irq_arbiter.sv
// Picks the most urgent eligible source; ties go to the lowest index.
module irq_arbiter #(
  parameter int N_SRC  = 5,
  parameter int PRIO_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic [N_SRC-1:0]        pend,
  input  logic [N_SRC-1:0]        en,
  input  logic [N_SRC*PRIO_W-1:0] prio_flat,
  output logic                    best_vld,
  output logic [IDX_W-1:0]        best_idx,
  output logic [PRIO_W-1:0]       best_prio
);

  always_comb begin
    best_vld  = 1'b0;
    best_idx  = '0;
    best_prio = '1;
    // Strict compare while scanning upward keeps the lowest index on ties
    for (int i = 0; i < N_SRC; i++) begin
      if (pend[i] && en[i] &&
          (!best_vld || (prio_flat[i*PRIO_W +: PRIO_W] < best_prio))) begin
        best_vld  = 1'b1;
        best_idx  = IDX_W'(i);
        best_prio = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end

endmodule

// File: rtl/irq_frame_stack.sv
// Holds the base priority and handler index of each interrupted context.
module irq_frame_stack #(
  parameter int DEPTH      = 5,
  parameter int BASE_W     = 9,
  parameter int IDX_W      = 3,
  parameter int EMPTY_BASE = 256,
  parameter int LVL_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [BASE_W-1:0] push_base,
  input  logic [IDX_W-1:0]  push_idx,
  output logic [BASE_W-1:0] top_base,
  output logic [IDX_W-1:0]  top_idx,
  output logic [LVL_W-1:0]  level
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [BASE_W-1:0] base_mem [DEPTH];
  logic [IDX_W-1:0]  idx_mem  [DEPTH];
  logic [AW-1:0]     wr_addr;
  logic [AW-1:0]     rd_addr;

  assign wr_addr = AW'(level);
  assign rd_addr = AW'(level - LVL_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)    level <= '0;
    else if (push) level <= level + LVL_W'(1);
    else if (pop)  level <= level - LVL_W'(1);
  end

  always_ff @(posedge clk) begin
    if (push) begin
      base_mem[wr_addr] <= push_base;
      idx_mem[wr_addr]  <= push_idx;
    end
  end

  assign top_base = (level == '0) ? BASE_W'(EMPTY_BASE) : base_mem[rd_addr];
  assign top_idx  = (level == '0) ? '0 : idx_mem[rd_addr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (level < LVL_W'(DEPTH))) else $error("frame stack overflow"); // R5

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (level != '0)) else $error("frame stack underflow"); // R11

  AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop)) else $error("push and pop together"); // R8

endmodule

// File: rtl/irq_nest_seq.sv
// Top: entry/exit sequencer with nesting, tail-chaining and late arrival.
module irq_nest_seq
  import irq_seq_pkg::*;
#(
  parameter int N_SRC       = 5,
  parameter int PRIO_W      = 8,
  parameter int FRAME_WORDS = 8,
  parameter int CHAIN_CYC   = 3,
  parameter int IDX_W       = $clog2(N_SRC),
  parameter int BASE_W      = PRIO_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_req,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              cfg_en,
  input  logic              hdl_ret,
  output logic              busy,
  output logic              vec_start,
  output logic [IDX_W-1:0]  vec_idx,
  output logic [BASE_W-1:0] base_prio,
  output logic [N_SRC-1:0]  pend_o,
  output logic [N_SRC-1:0]  act_o
);

  localparam int IDLE_BASE  = 1 << PRIO_W;
  localparam int CNT_TOP    = (FRAME_WORDS > CHAIN_CYC) ? FRAME_WORDS : CHAIN_CYC;
  localparam int CNT_W      = $clog2(CNT_TOP + 1);
  localparam int LVL_W      = $clog2(N_SRC + 1);
  localparam logic [CNT_W-1:0] LAST_WORD  = CNT_W'(FRAME_WORDS - 1);
  localparam logic [CNT_W-1:0] LAST_CHAIN = CNT_W'(CHAIN_CYC - 1);

  sq_state_e          st, st_n;
  logic [CNT_W-1:0]   cnt, cnt_n;
  logic [BASE_W-1:0]  base, base_n;
  logic [IDX_W-1:0]   cur, cur_n;
  logic               vs_q;
  logic [IDX_W-1:0]   vi_q;

  logic [N_SRC-1:0]        pend, en, act;
  logic [N_SRC*PRIO_W-1:0] prio_flat;
  logic                    best_vld;
  logic [IDX_W-1:0]        best_idx;
  logic [PRIO_W-1:0]       best_prio;
  logic                    push, pop, take, drop;
  logic [BASE_W-1:0]       top_base;
  logic [IDX_W-1:0]        top_idx;
  logic [LVL_W-1:0]        level;
  logic                    beats_base, beats_top;

  irq_src_bank #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .req(irq_req),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_prio(cfg_prio), .cfg_en(cfg_en),
    .take_vld(take), .take_idx(best_idx), .drop_vld(drop), .drop_idx(cur),
    .pend(pend), .en(en), .act(act), .prio_flat(prio_flat)
  );

  irq_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .pend(pend), .en(en), .prio_flat(prio_flat),
    .best_vld(best_vld), .best_idx(best_idx), .best_prio(best_prio)
  );

  irq_frame_stack #(.DEPTH(N_SRC), .BASE_W(BASE_W), .IDX_W(IDX_W),
                    .EMPTY_BASE(IDLE_BASE), .LVL_W(LVL_W)) u_frames (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .push_base(base), .push_idx(cur),
    .top_base(top_base), .top_idx(top_idx), .level(level)
  );

  // Urgency tests against the running level and against the level a return goes to
  assign beats_base = best_vld && ({1'b0, best_prio} < base);
  assign beats_top  = best_vld && ({1'b0, best_prio} < top_base);

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    base_n = base;
    cur_n  = cur;
    push   = 1'b0;
    pop    = 1'b0;
    take   = 1'b0;
    drop   = 1'b0;
    unique case (st)
      SQ_THREAD: begin
        if (beats_base) begin
          st_n  = SQ_STACK;
          cnt_n = '0;
          push  = 1'b1;
        end
      end
      SQ_STACK: begin
        if (cnt == LAST_WORD) begin
          // Late arrival: the winner is chosen only now
          if (beats_base) begin
            take = 1'b1;
            st_n = SQ_RUN;
          end else begin
            st_n  = SQ_UNSTACK;
            cnt_n = '0;
          end
        end else begin
          cnt_n = cnt + CNT_W'(1);
        end
      end
      SQ_RUN: begin
        if (hdl_ret) begin
          drop  = 1'b1;
          cnt_n = '0;
          st_n  = beats_top ? SQ_CHAIN : SQ_UNSTACK;
        end else if (beats_base) begin
          st_n  = SQ_STACK;
          cnt_n = '0;
          push  = 1'b1;
        end
      end
      SQ_CHAIN: begin
        if (cnt == LAST_CHAIN) begin
          if (beats_top) begin
            take = 1'b1;
            st_n = SQ_RUN;
          end else begin
            st_n  = SQ_UNSTACK;
            cnt_n = '0;
          end
        end else begin
          cnt_n = cnt + CNT_W'(1);
        end
      end
      SQ_UNSTACK: begin
        if (cnt == LAST_WORD) begin
          pop    = 1'b1;
          base_n = top_base;
          cur_n  = top_idx;
          st_n   = (level == LVL_W'(1)) ? SQ_THREAD : SQ_RUN;
        end else begin
          cnt_n = cnt + CNT_W'(1);
        end
      end
      default: st_n = SQ_THREAD;
    endcase
    if (take) begin
      base_n = {1'b0, best_prio};
      cur_n  = best_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= SQ_THREAD;
      cnt  <= '0;
      base <= BASE_W'(IDLE_BASE);
      cur  <= '0;
      vs_q <= 1'b0;
      vi_q <= '0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      base <= base_n;
      cur  <= cur_n;
      vs_q <= take;
      if (take) vi_q <= best_idx;
    end
  end

  assign busy      = (st == SQ_STACK) || (st == SQ_UNSTACK);
  assign vec_start = vs_q;
  assign vec_idx   = vi_q;
  assign base_prio = base;
  assign pend_o    = pend;
  assign act_o     = act;

  AST_IDLE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_THREAD) |-> (base == BASE_W'(IDLE_BASE))) else $error("idle base wrong"); // R2

  AST_ENTRY_URGENT: assert property (@(posedge clk) disable iff (!rst_n)
    vs_q |-> (base < top_base)) else $error("entry not more urgent than saved level"); // R3

  AST_VEC_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    vs_q |-> act[vi_q]) else $error("vectored source not active"); // R4

  AST_RUN_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_RUN) |-> ($countones(act) == int'(level))) else $error("active count vs frames"); // R5

  AST_CHAIN_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_CHAIN) |-> (cnt < CNT_W'(CHAIN_CYC))) else $error("chain too long"); // R6

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cnt) == LAST_WORD)) else $error("busy run not full frame"); // R8

endmodule

// File: tb/test_irq_nest_seq.sv
`timescale 1ns/1ps
module test_irq_nest_seq;
  localparam int N = 5, PW = 8, IW = 3, BW = 9, IDLE = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0]  irq_req = '0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [PW-1:0] cfg_prio = '0;
  logic          cfg_en = 1'b0;
  logic          hdl_ret = 1'b0;
  logic          busy, vec_start;
  logic [IW-1:0] vec_idx;
  logic [BW-1:0] base_prio;
  logic [N-1:0]  pend_o, act_o;

  int pr[N];
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  irq_nest_seq i_irq_nest_seq (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_prio(cfg_prio), .cfg_en(cfg_en),
    .hdl_ret(hdl_ret), .busy(busy), .vec_start(vec_start), .vec_idx(vec_idx),
    .base_prio(base_prio), .pend_o(pend_o), .act_o(act_o)
  );

  task automatic chk(input string tag, input string what, input bit ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic eq(input string tag, input string what, input int act, input int exp);
    chk(tag, what, act == exp, act, exp);
  endtask

  task automatic set_src(input int i, input int p, input bit e);
    cfg_we = 1'b1; cfg_idx = IW'(i); cfg_prio = PW'(p); cfg_en = e;
    @(negedge clk);
    cfg_we = 1'b0;
    pr[i] = p;
  endtask

  task automatic pulse_req(input logic [N-1:0] m);
    irq_req = m;
    @(negedge clk);
    irq_req = '0;
  endtask

  task automatic pulse_ret();
    hdl_ret = 1'b1;
    @(negedge clk);
    hdl_ret = 1'b0;
  endtask

  task automatic wait_vec(output int idx, output int bcnt, output int cyc);
    idx = -1; bcnt = 0; cyc = 1;
    while (!vec_start && cyc < 40) begin
      if (busy) bcnt++;
      @(negedge clk);
      cyc++;
    end
    if (vec_start) idx = int'(vec_idx);
  endtask

  task automatic watch(input int n, output int bcnt, output int vcnt);
    bcnt = 0; vcnt = 0;
    for (int k = 0; k < n; k++) begin
      if (busy) bcnt++;
      if (vec_start) vcnt++;
      @(negedge clk);
    end
  endtask

  // Return of the last handler: full restore, idle level back
  task automatic finish_return();
    int b, v;
    pulse_ret();
    watch(12, b, v);
    eq("R11", "restore busy cycles", b, 8);
    eq("R11", "vec_start on final return", v, 0);
    eq("R11", "base after final return", int'(base_prio), IDLE);
    eq("R11", "active after final return", int'(act_o), 0);
  endtask

  task automatic cfg_layout(input int k);
    for (int i = 0; i < N; i++) set_src(i, (i * 37 + k * 91 + 13) % 200 + 20, 1'b1);
  endtask

  task automatic test_pair(input int a, input int b);
    int idx, bc, cy, v;
    pulse_req(N'(1 << a));
    wait_vec(idx, bc, cy);
    eq("R4", "first vector", idx, a);
    eq("R8", "save busy cycles", bc, 8);
    eq("R4", "base after entry", int'(base_prio), pr[a]);
    eq("R4", "active bit set", int'(act_o[a]), 1);
    eq("R4", "pending bit cleared", int'(pend_o[a]), 0);
    pulse_req(N'(1 << b));
    if (pr[b] < pr[a]) begin
      wait_vec(idx, bc, cy);
      eq("R5", "nested vector", idx, b);
      eq("R5", "nested save busy", bc, 8);
      eq("R5", "nested base", int'(base_prio), pr[b]);
      pulse_ret();
      watch(12, bc, v);
      eq("R5", "nested restore busy", bc, 8);
      eq("R5", "vec on nested return", v, 0);
      eq("R5", "base back to outer", int'(base_prio), pr[a]);
      eq("R5", "outer still active", int'(act_o), 1 << a);
    end else begin
      watch(12, bc, v);
      eq("R3", "no preempt vector", v, 0);
      eq("R3", "no preempt busy", bc, 0);
      eq("R3", "later request pending", int'(pend_o[b]), 1);
      pulse_ret();
      wait_vec(idx, bc, cy);
      eq("R6", "chained vector", idx, b);
      eq("R6", "chain busy cycles", bc, 0);
      chk("R6", "chain latency", cy <= 6, cy, 6);
      eq("R6", "base after chain", int'(base_prio), pr[b]);
    end
    finish_return();
  endtask

  task automatic test_late(input int a, input int b);
    int idx, bc, cy;
    pulse_req(N'(1 << a));
    @(negedge clk);
    @(negedge clk);
    pulse_req(N'(1 << b));
    wait_vec(idx, bc, cy);
    eq("R7", "late arrival wins", idx, b);
    eq("R7", "base is late source", int'(base_prio), pr[b]);
    eq("R7", "first source still pending", int'(pend_o[a]), 1);
    pulse_ret();
    wait_vec(idx, bc, cy);
    eq("R7", "first source chained", idx, a);
    eq("R6", "chain without busy", bc, 0);
    finish_return();
  endtask

  // Raise all sources together; handlers must appear in priority order
  task automatic run_all(input string tag);
    int idx, bc, cy;
    logic [N-1:0] left = '1;
    pulse_req('1);
    for (int s = 0; s < N; s++) begin
      int e = -1;
      for (int i = 0; i < N; i++)
        if (left[i] && (e < 0 || pr[i] < pr[e])) e = i;
      left[e] = 1'b0;
      if (s > 0) pulse_ret();
      wait_vec(idx, bc, cy);
      eq(tag, "service order", idx, e);
      eq("R1", "base follows chosen", int'(base_prio), pr[e]);
    end
    finish_return();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int b, v, idx, bc, cy;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    eq("R2", "reset base", int'(base_prio), IDLE);
    eq("R2", "reset busy", int'(busy), 0);
    eq("R2", "reset vec_start", int'(vec_start), 0);
    eq("R2", "reset pending", int'(pend_o), 0);
    eq("R2", "reset active", int'(act_o), 0);

    for (int k = 0; k < 2; k++) begin
      cfg_layout(k);
      for (int a = 0; a < N; a++)
        for (int c = 0; c < N; c++)
          if (a != c) test_pair(a, c);
    end

    for (int k = 0; k < 2; k++) begin
      cfg_layout(k);
      for (int a = 0; a < N; a++)
        for (int c = 0; c < N; c++)
          if (a != c && pr[c] < pr[a]) test_late(a, c);
    end

    for (int k = 0; k < 4; k++) begin
      cfg_layout(k);
      run_all("R1");
    end
    for (int i = 0; i < N; i++) set_src(i, 77, 1'b1);
    run_all("R9");
    set_src(0, 40, 1'b1); set_src(1, 40, 1'b1); set_src(2, 20, 1'b1);
    set_src(3, 20, 1'b1); set_src(4, 90, 1'b1);
    run_all("R9");

    // Equal priority never preempts
    set_src(0, 60, 1'b1); set_src(1, 60, 1'b1);
    test_pair(0, 1);
    test_pair(1, 0);

    // Disabled source waits until enabled
    set_src(2, 30, 1'b0);
    pulse_req(N'(1 << 2));
    watch(15, b, v);
    eq("R10", "disabled not vectored", v, 0);
    eq("R10", "disabled no busy", b, 0);
    eq("R10", "disabled still pending", int'(pend_o[2]), 1);
    set_src(2, 30, 1'b1);
    wait_vec(idx, bc, cy);
    eq("R10", "vectored once enabled", idx, 2);
    finish_return();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule